// File: doc/BRIEF.md
# Double-Buffered Serial Byte Transmitter

This block takes bytes from a host and sends them one bit per bit period to an FSK modulator. The host writes a byte into a holding register. The byte moves into a shift register at the next bit boundary, and the shift register presents it on a serial output, most significant bit first. When the shift register is free to take a byte, the block raises a request flag. The host reads that flag, together with an idle flag, through a status strobe that clears both. The request flag also drives a shared active-low interrupt.

When a byte finishes and the holding register is empty, the block keeps the line busy with a programmable 8-bit filler pattern and raises the idle flag. The bit rate is either 1200 or 2400 bit/s, derived from the system clock frequency parameter.

Once transmit mode is entered, the host waits for the first request before it writes. The idle flag seen together with that first request is stale, and the host discards it. Leaving transmit mode clears everything and returns the line to the mark level (logic 1).

Top module: `byte_tx_serializer`

## Requirements
- R1: While reset is asserted and after it is released, `ser_out` is 1, `irq_n` is 1, `bit_stb` is 0 and both status flags are 0.
- R2: The bit period is CLK_HZ/1200 clock cycles when `rate_fast` is 0 and CLK_HZ/2400 cycles when it is 1. The first bit period ends that many cycles after transmit mode is entered, and every new bit on `ser_out` comes with a one-cycle `bit_stb` pulse.
- R3: At the first bit boundary after transmit mode is entered, the request flag and the idle flag are both set. The shifter starts sending the idle pattern.
- R4: A byte written while the shifter holds no data byte (it is sending filler or nothing) preempts the filler. Its MSB appears on `ser_out` with `bit_stb` and the request flag set, between 1 and one bit period after the write.
- R5: A byte written while a data byte is shifting waits in the holding register. It reaches `ser_out`, and the request flag is set again, exactly 8 bit periods after the previous data byte started.
- R6: Each byte is sent MSB first as 8 bits, one per bit period.
- R7: If the holding register is empty when a byte ends, the idle pattern is loaded and sent MSB first, again for every filler byte. Each load sets the idle flag and leaves the request flag unchanged.
- R8: A `stat_rd` pulse clears both flags at the next clock edge. If a flag is being set on that same edge, the set wins.
- R9: `irq_n` is 0 exactly while the request flag is 1.
- R10: With `tx_en` at 0, the holding register, shifter and flags are cleared, `ser_out` is 1 from the next cycle, and host writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit mode enable |
| rate_fast | input | 1 | 0 selects 1200 bit/s, 1 selects 2400 bit/s |
| wr_en | input | 1 | Host write strobe for the data register |
| wr_data | input | 8 | Byte written by the host |
| idle_pat | input | 8 | Filler pattern sent when no data is waiting |
| stat_rd | input | 1 | Status read strobe; clears both flags |
| stat_req | output | 1 | Request flag: the holding register may be written |
| stat_idle | output | 1 | Idle flag: a filler byte has started |
| ser_out | output | 1 | Serial bit to the modulator |
| bit_stb | output | 1 | One-cycle pulse when a new bit is presented |
| irq_n | output | 1 | Active-low interrupt driven by the request flag |

## Verification
All outputs are registered. Each effect becomes visible in the cycle after the clock edge that samples its cause. The request and idle flags, `bit_stb` and the new `ser_out` bit all change together on a bit boundary. The bench drives inputs on the falling edge and samples on the falling edge that follows each rising edge.

It counts rising edges and checks three timings. The first boundary falls exactly one bit period after enable. A preempting write appears within one bit period. A held byte starts exactly eight bit periods after the previous data byte. A status read is checked in the cycle right after its strobe, and a read that lands on a boundary edge is checked to leave the flag set.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;
  localparam int BYTE_W = 8;
  localparam int LEFT_W = $clog2(BYTE_W + 1);
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [LEFT_W-1:0] left_t;
endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int CLK_HZ   = 96000,
  parameter int SLOW_BPS = 1200,
  parameter int FAST_BPS = 2400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rate_fast,
  output logic tick
);
  localparam int DIV_SLOW = CLK_HZ / SLOW_BPS;
  localparam int DIV_FAST = CLK_HZ / FAST_BPS;
  localparam int DIV_MAX  = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW       = $clog2(DIV_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  assign lim  = rate_fast ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
  assign tick = run && (cnt_q >= lim);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tx_shift_path.sv
module tx_shift_path
  import tx_ser_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tx_en,
  input  logic  tick,
  input  logic  wr_en,
  input  byte_t wr_data,
  input  byte_t idle_pat,
  output logic  ser_out,
  output logic  bit_stb,
  output logic  req_set,
  output logic  idle_set
);
  byte_t hold_q, hold_d, sh_q, sh_d;
  left_t left_q, left_d;
  logic  full_q, full_d, data_q, data_d, start_q, start_d, stb_q, stb_d;
  logic  boundary, take, idle_ld, shift;

  assign boundary = (left_q <= left_t'(1));
  assign take     = tick && full_q && (boundary || !data_q);
  assign idle_ld  = tick && !take && boundary;
  assign shift    = tick && !take && !boundary;

  always_comb begin
    hold_d  = hold_q;
    full_d  = full_q;
    sh_d    = sh_q;
    left_d  = left_q;
    data_d  = data_q;
    start_d = start_q | tick;
    stb_d   = tick;
    if (!tx_en) begin
      full_d  = 1'b0;
      left_d  = '0;
      data_d  = 1'b0;
      start_d = 1'b0;
      stb_d   = 1'b0;
    end else begin
      if (take) begin
        sh_d   = hold_q;
        left_d = left_t'(BYTE_W);
        data_d = 1'b1;
        full_d = 1'b0;
      end else if (idle_ld) begin
        sh_d   = idle_pat;
        left_d = left_t'(BYTE_W);
        data_d = 1'b0;
      end else if (shift) begin
        sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
        left_d = left_q - 1'b1;
      end
      if (wr_en) begin
        hold_d = wr_data;
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      full_q  <= 1'b0;
      sh_q    <= '0;
      left_q  <= '0;
      data_q  <= 1'b0;
      start_q <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      full_q  <= full_d;
      sh_q    <= sh_d;
      left_q  <= left_d;
      data_q  <= data_d;
      start_q <= start_d;
      stb_q   <= stb_d;
    end
  end

  assign ser_out  = (left_q != '0) ? sh_q[BYTE_W-1] : 1'b1;
  assign bit_stb  = stb_q;
  assign req_set  = take || (tick && !start_q);
  assign idle_set = idle_ld;

  // R10
  hold_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !full_q);
  // R5
  data_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_q) |-> $past(full_q));
endmodule

// File: rtl/tx_status_flags.sv
module tx_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic req_set,
  input  logic idle_set,
  input  logic rd_stb,
  output logic req_flag,
  output logic idle_flag,
  output logic irq_n
);
  logic req_q, req_d, idl_q, idl_d;

  always_comb begin
    if (!tx_en)        req_d = 1'b0;
    else if (req_set)  req_d = 1'b1;
    else if (rd_stb)   req_d = 1'b0;
    else               req_d = req_q;
    if (!tx_en)        idl_d = 1'b0;
    else if (idle_set) idl_d = 1'b1;
    else if (rd_stb)   idl_d = 1'b0;
    else               idl_d = idl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      idl_q <= 1'b0;
    end else begin
      req_q <= req_d;
      idl_q <= idl_d;
    end
  end

  assign req_flag  = req_q;
  assign idle_flag = idl_q;
  assign irq_n     = ~req_q;

  // R8
  rd_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !req_set |=> !req_q);
  // R8
  set_beats_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && req_set |=> req_q);
endmodule

// File: rtl/byte_tx_serializer.sv
module byte_tx_serializer
  import tx_ser_pkg::*;
#(
  parameter int CLK_HZ = 96000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_en,
  input  logic                rate_fast,
  input  logic                wr_en,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [BYTE_W-1:0]   idle_pat,
  input  logic                stat_rd,
  output logic                stat_req,
  output logic                stat_idle,
  output logic                ser_out,
  output logic                bit_stb,
  output logic                irq_n
);
  logic tick, req_set, idle_set;

  tx_bit_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(tx_en), .rate_fast(rate_fast), .tick(tick)
  );

  tx_shift_path u_path (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tick(tick),
    .wr_en(wr_en), .wr_data(wr_data), .idle_pat(idle_pat),
    .ser_out(ser_out), .bit_stb(bit_stb),
    .req_set(req_set), .idle_set(idle_set)
  );

  tx_status_flags u_flags (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .req_set(req_set), .idle_set(idle_set), .rd_stb(stat_rd),
    .req_flag(stat_req), .idle_flag(stat_idle), .irq_n(irq_n)
  );

  // R9
  irq_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(tick));
  // R10
  line_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> ser_out && !bit_stb);
endmodule

// File: tb/byte_tx_serializer_bench.sv
module byte_tx_serializer_bench;
  localparam int CLK_HZ = 96000;
  localparam int DIV_S  = CLK_HZ / 1200;
  localparam int DIV_F  = CLK_HZ / 2400;
  localparam int NVEC   = 4;
  // {rate_fast, first byte, second byte, idle pattern}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 8'hA5, 8'h3C, 8'h7E},
    {1'b1, 8'h01, 8'h80, 8'hFF},
    {1'b0, 8'hFF, 8'h00, 8'h55},
    {1'b1, 8'hC3, 8'h5A, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, rate_fast = 1'b0, wr_en = 1'b0, stat_rd = 1'b0;
  logic [7:0] wr_data = 8'h00, idle_pat = 8'h00;
  logic stat_req, stat_idle, ser_out, bit_stb, irq_n;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  byte_tx_serializer #(.CLK_HZ(CLK_HZ)) u_byte_tx_serializer (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rate_fast(rate_fast),
    .wr_en(wr_en), .wr_data(wr_data), .idle_pat(idle_pat), .stat_rd(stat_rd),
    .stat_req(stat_req), .stat_idle(stat_idle), .ser_out(ser_out),
    .bit_stb(bit_stb), .irq_n(irq_n)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_stb();
    int guard = 0;
    do begin step(); guard++; end while (!bit_stb && guard < 5000);
    if (!bit_stb) chk(1'b0, "R2 bit_stb timeout", 0, 1);
  endtask

  task automatic read_stat();
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int div, n, t1;
    logic [7:0] d1, d2, ip;
    // R1 reset state
    step(); step();
    chk(ser_out == 1'b1 && irq_n == 1'b1 && !bit_stb, "R1 outputs in reset",
        {ser_out, irq_n, bit_stb}, 3'b110);
    chk(!stat_req && !stat_idle, "R1 flags in reset", {stat_req, stat_idle}, 0);
    rst_n = 1'b1; step(); step();
    chk(ser_out == 1'b1 && irq_n == 1'b1 && !stat_req && !stat_idle, "R1 after release",
        {ser_out, irq_n, stat_req, stat_idle}, 4'b1100);

    for (int v = 0; v < NVEC; v++) begin
      {rate_fast, d1, d2, ip} = VEC[v];
      idle_pat = ip;
      div = rate_fast ? DIV_F : DIV_S;
      tx_en = 1'b1;
      repeat (div - 1) step();
      chk(irq_n == 1'b1, "R2 no boundary before one period", irq_n, 1);
      step();
      chk(irq_n == 1'b0 && stat_req, "R3 first request at one period", irq_n, 0);
      chk(stat_idle == 1'b1, "R3 stale idle flag on entry", stat_idle, 1);
      chk(bit_stb && ser_out == ip[7], "R3 filler starts", ser_out, ip[7]);
      read_stat();
      chk(!stat_req && !stat_idle && irq_n, "R8 read clears flags",
          {stat_req, stat_idle}, 0);
      wr_data = d1; wr_en = 1'b1; step(); wr_en = 1'b0;
      n = 0;
      do begin step(); n++; end while (!bit_stb && n < 5000);
      chk(n >= 1 && n <= div, "R4 preempt delay within one period", n, div);
      chk(ser_out == d1[7] && stat_req, "R4 MSB and request", ser_out, d1[7]);
      t1 = cyc;
      read_stat();
      wr_data = d2; wr_en = 1'b1; step(); wr_en = 1'b0;
      for (int b = 6; b >= 0; b--) begin
        wait_stb();
        chk(ser_out == d1[b], "R6 first byte bit", ser_out, d1[b]);
      end
      chk(!stat_req, "R5 no request while held", stat_req, 0);
      wait_stb();
      chk(cyc - t1 == 8 * div, "R5 held byte after eight periods", cyc - t1, 8 * div);
      chk(ser_out == d2[7] && stat_req && !irq_n, "R5 held MSB and request R9",
          ser_out, d2[7]);
      read_stat();
      for (int b = 6; b >= 0; b--) begin
        wait_stb();
        chk(ser_out == d2[b], "R6 second byte bit", ser_out, d2[b]);
      end
      wait_stb();
      chk(ser_out == ip[7] && stat_idle && !stat_req, "R7 filler after data",
          {ser_out, stat_idle, stat_req}, {ip[7], 2'b10});
      read_stat();
      for (int b = 6; b >= 0; b--) begin
        wait_stb();
        chk(ser_out == ip[b], "R7 filler bit", ser_out, ip[b]);
      end
      wait_stb();
      chk(ser_out == ip[7] && stat_idle && !stat_req, "R7 filler repeats",
          {ser_out, stat_idle, stat_req}, {ip[7], 2'b10});
      tx_en = 1'b0; step();
      chk(ser_out && irq_n && !stat_req && !stat_idle && !bit_stb, "R10 disable clears",
          {ser_out, irq_n, stat_req, stat_idle}, 4'b1100);
      step();
    end

    // R10 write while disabled has no effect
    rate_fast = 1'b1; idle_pat = 8'hF0;
    wr_data = 8'h0F; wr_en = 1'b1; step(); wr_en = 1'b0; step();
    tx_en = 1'b1;
    wait_stb();
    chk(ser_out == 1'b1 && stat_req, "R10 ignored write, filler first", ser_out, 1);
    for (int b = 6; b >= 0; b--) begin
      wait_stb();
      chk(ser_out == idle_pat[b], "R10 filler bit after ignored write", ser_out, idle_pat[b]);
    end
    tx_en = 1'b0; step(); step();

    // R8 read on the same edge as a set: set wins
    rate_fast = 1'b0; tx_en = 1'b1;
    repeat (DIV_S - 1) step();
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
    chk(stat_req && !irq_n, "R8 set wins over read", stat_req, 1);
    read_stat();
    chk(!stat_req && irq_n, "R9 irq released after read", irq_n, 1);
    tx_en = 1'b0; step();
    finish_run();
  end
endmodule